// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block takes one fast source clock and fans it out as four groups of divided clocks. Bank A and bank B each drive five identical outputs, bank C drives four, and one feedback output stands alone. The source is either the fast oscillator input or one of two reference clocks. The choice between the two references is made by a select pin. The whole divider chain runs on the chosen clock.

Division happens in two stages. A shared prescaler divides by 1, 2 or 4. After it, each group has its own post-divider with a different set of ratios. Every output has a 50% duty cycle, the ÷6 and ÷12 ratios included. All counters leave reset on the same source edge, so the output edges stay in a fixed phase relationship.

An active-low clock stop parks banks A, B and C low and leaves the feedback output running. An active-low enable/reset puts every output into high impedance and clears all divider state. The ratio selects are captured only while the block is held in reset.

Top module: `clkbank_divider`

## Requirements
- R1: The prescaler ratio P comes from `pre_sel`. When bit 1 is 1, P = 1 and bit 0 is ignored. The code 00 gives P = 2 and the code 01 gives P = 4.
- R2: The bank A ratio is P×2 when `sel_a` is 0 and P×4 when it is 1. Bank B follows the same rule with `sel_b`. All bits of a bank always carry the same value.
- R3: The bank C ratio is P×4 when `sel_c` is 0 and P×6 when it is 1.
- R4: The feedback ratio is set by `fb_sel`. The codes give P×4 for 00, P×8 for 01, P×6 for 10 and P×12 for 11.
- R5: Every output stays high for exactly half its ratio and low for exactly half its ratio, counted in source cycles.
- R6: When `pll_on` is 1, the dividers are clocked from `src_clk`. When `pll_on` is 0, they are clocked from `ref0_clk` if `ref_pick` is 0 and from `ref1_clk` if `ref_pick` is 1.
- R7: While `stop_n` is low, banks A, B and C settle low and stay low, and the feedback output keeps toggling. When `stop_n` returns high, the banks resume toggling.
- R8: Stopping or restarting a bank never produces a high phase shorter than that bank's half ratio.
- R9: While `oe_rst_n` is low, every output is high impedance and all divider state is cleared. After release, all outputs start low. Each output rises for the first time exactly its half ratio after one common start edge.
- R10: `pre_sel`, `sel_a`, `sel_b`, `sel_c` and `fb_sel` are captured only while the block is in reset. A change to any of them while running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast oscillator clock |
| ref0_clk | input | 1 | Reference clock 0 |
| ref1_clk | input | 1 | Reference clock 1 |
| ref_pick | input | 1 | Reference select, 1 = ref1_clk |
| pll_on | input | 1 | 1 = clock from src_clk, 0 = clock from chosen reference |
| pre_sel | input | 2 | Shared prescaler select |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| fb_sel | input | 2 | Feedback ratio select |
| stop_n | input | 1 | Active-low stop for banks A, B, C |
| oe_rst_n | input | 1 | Active-low output enable and divider reset |
| qa | output | 5 | Bank A clocks |
| qb | output | 5 | Bank B clocks |
| qc | output | 4 | Bank C clocks |
| fb_q | output | 1 | Feedback clock |

## Verification
Two functions can act on the same cycle. A stop request can take hold at the same edge where a bank's counter reaches its terminal count and the bank would rise. The same holds when the stop is released. Randomised ratio settings are combined with stop assertion and release at arbitrary points in the waveform. The bench measures every high phase on the bank outputs and flags any high phase that is shorter than the expected half ratio. It also checks that the feedback output keeps toggling throughout.

// File: rtl/clkbank_divider.sv
module clkbank_divider #(
  parameter int A_OUTS = 5,
  parameter int B_OUTS = 5,
  parameter int C_OUTS = 4
) (
  input  logic              src_clk,
  input  logic              ref0_clk,
  input  logic              ref1_clk,
  input  logic              ref_pick,
  input  logic              pll_on,
  input  logic [1:0]        pre_sel,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c,
  input  logic [1:0]        fb_sel,
  input  logic              stop_n,
  input  logic              oe_rst_n,
  output logic [A_OUTS-1:0] qa,
  output logic [B_OUTS-1:0] qb,
  output logic [C_OUTS-1:0] qc,
  output logic              fb_q
);
  localparam int NCH = 4;
  localparam int CW  = 3;

  logic root_clk;
  assign root_clk = pll_on ? src_clk : (ref_pick ? ref1_clk : ref0_clk);

  logic rs1, run;
  always_ff @(posedge root_clk or negedge oe_rst_n)
    if (!oe_rst_n) begin
      rs1 <= 1'b0;
      run <= 1'b0;
    end else begin
      rs1 <= 1'b1;
      run <= rs1;
    end

  logic [1:0]               pre_lim;
  logic [NCH-1:0][CW-1:0]   hm1;
  always_ff @(posedge root_clk)
    if (!run) begin
      pre_lim <= pre_sel[1] ? 2'd0 : (pre_sel[0] ? 2'd3 : 2'd1);
      hm1[0]  <= sel_a ? 3'd1 : 3'd0;
      hm1[1]  <= sel_b ? 3'd1 : 3'd0;
      hm1[2]  <= sel_c ? 3'd2 : 3'd1;
      case (fb_sel)
        2'b00:   hm1[3] <= 3'd1;
        2'b01:   hm1[3] <= 3'd3;
        2'b10:   hm1[3] <= 3'd2;
        default: hm1[3] <= 3'd5;
      endcase
    end

  logic [1:0]             pre_cnt;
  logic                   tick;
  logic [NCH-1:0][CW-1:0] cnt;
  logic [NCH-1:0]         raw;
  assign tick = (pre_cnt == pre_lim);

  always_ff @(posedge root_clk or negedge oe_rst_n)
    if (!oe_rst_n) begin
      pre_cnt <= '0;
      cnt     <= '0;
      raw     <= '0;
    end else if (run) begin
      pre_cnt <= tick ? 2'd0 : pre_cnt + 2'd1;
      if (tick)
        for (int i = 0; i < NCH; i++)
          if (cnt[i] == hm1[i]) begin
            cnt[i] <= '0;
            raw[i] <= ~raw[i];
          end else begin
            cnt[i] <= cnt[i] + 3'd1;
          end
    end

  logic [1:0] stp;
  logic [2:0] gate;
  always_ff @(posedge root_clk or negedge oe_rst_n)
    if (!oe_rst_n) begin
      stp  <= '0;
      gate <= '1;
    end else begin
      stp <= {stp[0], ~stop_n};
      for (int i = 0; i < 3; i++)
        if (!raw[i]) gate[i] <= ~stp[1];
    end

  assign qa   = oe_rst_n ? {A_OUTS{raw[0] & gate[0]}} : 'z;
  assign qb   = oe_rst_n ? {B_OUTS{raw[1] & gate[1]}} : 'z;
  assign qc   = oe_rst_n ? {C_OUTS{raw[2] & gate[2]}} : 'z;
  assign fb_q = oe_rst_n ? raw[3] : 1'bz;
endmodule

// File: rtl/clkbank_divider_chk.sv
module clkbank_divider_chk (
  input logic             root_clk,
  input logic             oe_rst_n,
  input logic             run,
  input logic             tick,
  input logic [1:0]       pre_cnt,
  input logic [1:0]       pre_lim,
  input logic [3:0][2:0]  hm1,
  input logic [3:0]       raw,
  input logic [2:0]       gate
);
  AST_CFG_FROZEN: assert property (@(posedge root_clk) disable iff (!oe_rst_n)
    run && $past(run) |-> $stable(hm1) && $stable(pre_lim)); // R10

  AST_TOGGLE_ON_TICK: assert property (@(posedge root_clk) disable iff (!oe_rst_n)
    raw != $past(raw) |-> $past(tick) && $past(run)); // R1

  AST_PRE_BOUND: assert property (@(posedge root_clk) disable iff (!oe_rst_n)
    run |-> pre_cnt <= pre_lim); // R1

  AST_START_LOW: assert property (@(posedge root_clk) disable iff (!oe_rst_n)
    $rose(run) |-> raw == '0 && pre_cnt == '0); // R9

  AST_GATE_WHEN_LOW: assert property (@(posedge root_clk) disable iff (!oe_rst_n)
    gate != $past(gate) |-> (($past(raw[2:0]) & (gate ^ $past(gate))) == 3'b000)); // R8
endmodule

bind clkbank_divider clkbank_divider_chk u_chk (.*);

// File: tb/tb_clkbank_divider.sv
module tb_clkbank_divider;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic en_src = 0, en_r0 = 0, en_r1 = 0;
  logic ref_pick = 0, pll_on = 1, sel_a = 0, sel_b = 0, sel_c = 0;
  logic stop_n = 1, oe_rst_n = 0;
  logic [1:0] pre_sel = 0, fb_sel = 0;
  wire src_w = en_src & clk;
  wire r0_w  = en_r0 & clk;
  wire r1_w  = en_r1 & clk;
  wire [4:0] qa, qb;
  wire [3:0] qc;
  wire fbw;

  for (genvar i = 0; i < 5; i++) begin : g_pa
    pullup (qa[i]);
    pullup (qb[i]);
  end
  for (genvar i = 0; i < 4; i++) begin : g_pc
    pullup (qc[i]);
  end
  pullup (fbw);

  clkbank_divider dut (
    .src_clk(src_w), .ref0_clk(r0_w), .ref1_clk(r1_w), .ref_pick(ref_pick),
    .pll_on(pll_on), .pre_sel(pre_sel), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .fb_sel(fb_sel), .stop_n(stop_n), .oe_rst_n(oe_rst_n),
    .qa(qa), .qb(qb), .qc(qc), .fb_q(fbw));

  int errors = 0, checks = 0, cyc = 0;
  int exp_h[4], last_t[4], first_rise[4], n_tog[4], bad_int[4];
  int bad_uni = 0;
  logic [3:0] prev = '0;
  logic stop_mode = 0;
  string req_of[4] = '{"R2", "R2", "R3", "R4"};

  function automatic int exp_half(int ch, logic [1:0] ps, logic sa, logic sb,
                                  logic sc, logic [1:0] fs);
    int p, n;
    p = ps[1] ? 1 : (ps[0] ? 4 : 2);
    case (ch)
      0: n = sa ? 4 : 2;
      1: n = sb ? 4 : 2;
      2: n = sc ? 6 : 4;
      default: n = (fs == 2'd0) ? 4 : (fs == 2'd1) ? 8 : (fs == 2'd2) ? 6 : 12;
    endcase
    return p * n / 2;
  endfunction

  always @(negedge clk) begin
    logic [3:0] cur;
    cyc++;
    cur = {fbw, qc[0], qb[0], qa[0]};
    if (oe_rst_n && (qa != {5{qa[0]}} || qb != {5{qb[0]}} || qc != {4{qc[0]}}))
      bad_uni++;
    for (int i = 0; i < 4; i++)
      if (cur[i] !== prev[i]) begin
        if (n_tog[i] == 0) first_rise[i] = cyc;
        else if ((cyc - last_t[i]) != exp_h[i] && (!stop_mode || i == 3 || !cur[i]))
          bad_int[i]++;
        n_tog[i]++;
        last_t[i] = cyc;
      end
    prev = cur;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_case(input logic [1:0] ps, input logic sa, input logic sb,
                          input logic sc, input logic [1:0] fs, input int src);
    step();
    oe_rst_n = 0;
    en_src = 0; en_r0 = 0; en_r1 = 0;
    pre_sel = ps; sel_a = sa; sel_b = sb; sel_c = sc; fb_sel = fs;
    pll_on = (src == 0); ref_pick = (src == 2);
    en_src = (src == 0); en_r0 = (src == 1); en_r1 = (src == 2);
    stop_n = 1;
    repeat (4) step();
    chk(qa === 5'h1f && qb === 5'h1f && qc === 4'hf && fbw === 1'b1, "R9",
        "outputs high impedance in reset", {qa, qb, qc, fbw}, 15'h7fff);
    for (int i = 0; i < 4; i++) begin
      exp_h[i] = exp_half(i, ps, sa, sb, sc, fs);
      n_tog[i] = 0; bad_int[i] = 0;
    end
    bad_uni = 0; prev = '0; stop_mode = 0;
    oe_rst_n = 1;
    repeat (260) step();
    for (int i = 0; i < 4; i++) begin
      chk(n_tog[i] >= 4, "R6", $sformatf("ch%0d toggles from source %0d", i, src), n_tog[i], 4);
      chk(bad_int[i] == 0, req_of[i], $sformatf("ch%0d R5 phase width, half %0d", i, exp_h[i]),
          bad_int[i], 0);
      chk(first_rise[i] - exp_h[i] == first_rise[0] - exp_h[0], "R9",
          $sformatf("ch%0d common start", i), first_rise[i] - exp_h[i], first_rise[0] - exp_h[0]);
    end
    chk(bad_uni == 0, "R2", "bank bits identical", bad_uni, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a0, f0, nz;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 4; i++) begin n_tog[i] = 0; bad_int[i] = 0; exp_h[i] = 1; end
    run_case(2'b10, 0, 0, 0, 2'b00, 0);
    run_case(2'b11, 1, 0, 1, 2'b10, 1);
    run_case(2'b01, 1, 1, 1, 2'b11, 2);
    run_case(2'b00, 0, 1, 0, 2'b01, 1);

    run_case(2'b00, 0, 1, 1, 2'b01, 0);
    stop_mode = 1;
    repeat (7) step();
    stop_n = 0;
    repeat (40) step();
    f0 = n_tog[3]; nz = 0;
    repeat (30) begin
      step();
      if (qa != 0 || qb != 0 || qc != 0) nz++;
    end
    chk(nz == 0, "R7", "banks parked low", nz, 0);
    chk(n_tog[3] - f0 >= 3, "R7", "feedback keeps toggling", n_tog[3] - f0, 3);
    a0 = n_tog[0];
    stop_n = 1;
    repeat (60) step();
    chk(n_tog[0] - a0 >= 4, "R7", "bank A resumes", n_tog[0] - a0, 4);
    for (int i = 0; i < 4; i++)
      chk(bad_int[i] == 0, "R8", $sformatf("ch%0d high phase width", i), bad_int[i], 0);

    run_case(2'b00, 0, 0, 1, 2'b10, 0);
    for (int i = 0; i < 4; i++) bad_int[i] = 0;
    a0 = n_tog[0];
    pre_sel = 2'b11; sel_a = 1; sel_b = 1; sel_c = 0; fb_sel = 2'b11;
    repeat (150) step();
    chk(n_tog[0] - a0 >= 20, "R10", "bank A toggles at captured rate", n_tog[0] - a0, 20);
    for (int i = 0; i < 4; i++)
      chk(bad_int[i] == 0, "R10", $sformatf("ch%0d ratio unchanged", i), bad_int[i], 0);

    for (int k = 0; k < 8; k++) begin
      logic [1:0] ps, fs;
      ps = 2'($urandom_range(0, 3));
      fs = 2'($urandom_range(0, 3));
      run_case(ps, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), fs, int'($urandom_range(0, 2)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule